// File: doc/BRIEF.md
# Add-Compare Datapath with Selectable Parallel or Pipelined Form

The block takes two unsigned operands and a threshold on every clock cycle, adds the operands without losing the carry, and reports whether the sum is strictly larger than the threshold. The same arithmetic can be built in one of three architectural forms, selected by a parameter:
- **Reference:** a direct adder-into-comparator path, registered once.
- **Parallel:** two identical lanes, each given two clock periods per sample, with their results merged by a multiplexer.
- **Pipelined:** a register placed between the adder and the comparator.

Every form accepts one sample per clock period with no back-pressure, and every form must produce the same result stream. The forms differ only in latency. This lets the cost of each transformation be compared against the reference without changing what the surrounding logic sees, apart from the fixed delay.

A sample is offered by raising `in_valid` with the operands. Exactly one result pulse on `out_valid` follows it after a fixed number of clock edges that depends on the form. The asynchronous reset input is synchronised inside the block. Its release takes effect at the second rising clock edge after `rst_n` rises.

Top module: `add_cmp_dp`

## Requirements
- R1: For an accepted sample, `gt_out` equals 1 exactly when `a + b` is greater than `c`. The sum is computed with W+1 bits, so a carry out of the addition is kept and never wraps.
- R2: In the reference form (FORM = 0), the result of a sample taken at clock edge e is visible on the outputs from edge e onward, for one cycle.
- R3: In the pipelined form (FORM = 2), the result of a sample taken at edge e appears from edge e+1, for one cycle.
- R4: In the parallel form (FORM = 1), the result of a sample taken at edge e appears from edge e+2, for one cycle. Accepted samples are steered alternately to lane 0 and lane 1, counting only cycles with `in_valid` high, and at most one lane reports a result in any cycle.
- R5: In every form, each accepted sample produces exactly one `out_valid` pulse, results leave in arrival order, and a new sample can be accepted on every cycle.
- R6: A cycle with `in_valid` low produces no result, whatever the values on `a`, `b` and `c`.
- R7: While the synchronised reset is active, `out_valid` and `gt_out` are 0. Samples in flight when reset is asserted are discarded, and samples offered during reset are ignored.
- R8: `gt_out` is 0 in every cycle in which `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A sample is offered this cycle |
| a | input | W | First addend |
| b | input | W | Second addend |
| c | input | W | Threshold the sum is compared against |
| out_valid | output | 1 | Result of one sample is present |
| gt_out | output | 1 | Sum was greater than threshold; 0 when out_valid is 0 |

## Verification
The three forms are run side by side on the same stimulus. Each is compared cycle by cycle against a model that places every expected result at its form's fixed edge.

A wrong lane toggle in the parallel form shows up within two cycles: either a result is missing or doubled, or a result belongs to a different sample, which breaks the order. A lost carry or an off-by-one comparison appears on the first boundary sample, where the sum equals the threshold or overflows W bits. Stale state that survives a reset shows as an unexpected `out_valid` pulse in the first cycles after release.

// File: rtl/acd_pkg.sv
package acd_pkg;

  typedef enum logic [1:0] {
    FORM_REF  = 2'd0,
    FORM_PAR  = 2'd1,
    FORM_PIPE = 2'd2
  } acd_form_e;

  // clock edges from the sampling edge to the result edge, counting the sampling edge as 1
  function automatic int form_latency(acd_form_e f);
    case (f)
      FORM_REF:  return 1;
      FORM_PIPE: return 2;
      default:   return 3;
    endcase
  endfunction

endpackage

// File: rtl/acd_sum.sv
module acd_sum #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W:0]   sum
);
  assign sum = {1'b0, op_a} + {1'b0, op_b};
endmodule

// File: rtl/acd_cmp.sv
module acd_cmp #(
  parameter int W = 8
) (
  input  logic [W:0]   sum,
  input  logic [W-1:0] thr,
  output logic         above
);
  assign above = sum > {1'b0, thr};
endmodule

// File: rtl/acd_lane.sv
// One half-rate lane: operands are held for two cycles and the result is captured
// on the second edge after loading.
module acd_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic         done,
  output logic         res
);
  logic [W-1:0] opa_q, opb_q, opc_q, opa_d, opb_d, opc_d;
  logic         age1_q, age2_q, done_q, res_q;
  logic         age1_d, age2_d, done_d, res_d;
  logic [W:0]   sum_w;
  logic         above_w;

  acd_sum #(.W(W)) u_sum (.op_a(opa_q), .op_b(opb_q), .sum(sum_w));
  acd_cmp #(.W(W)) u_cmp (.sum(sum_w), .thr(opc_q), .above(above_w));

  always_comb begin
    opa_d  = ld ? a : opa_q;
    opb_d  = ld ? b : opb_q;
    opc_d  = ld ? c : opc_q;
    age1_d = ld;
    age2_d = age1_q;
    done_d = age2_q;
    res_d  = age2_q & above_w;
  end

  always_ff @(posedge clk) begin
    opa_q <= opa_d;
    opb_q <= opb_d;
    opc_q <= opc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age1_q <= 1'b0;
      age2_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= 1'b0;
    end else begin
      age1_q <= age1_d;
      age2_q <= age2_d;
      done_q <= done_d;
      res_q  <= res_d;
    end
  end

  assign done = done_q;
  assign res  = res_q;
endmodule

// File: rtl/add_cmp_dp.sv
module add_cmp_dp
  import acd_pkg::*;
#(
  parameter acd_form_e FORM = FORM_PAR,
  parameter int        W    = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic         out_valid,
  output logic         gt_out
);
  localparam int LANES = 2;

  logic             rst_meta, rst_q;
  logic             out_v, out_g;
  logic [LANES-1:0] lane_done;

  // asynchronous assertion, release after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  generate
    if (FORM == FORM_REF) begin : g_ref
      logic [W:0] sum_w;
      logic       above_w, v_q, g_q, v_d, g_d;

      acd_sum #(.W(W)) u_sum (.op_a(a), .op_b(b), .sum(sum_w));
      acd_cmp #(.W(W)) u_cmp (.sum(sum_w), .thr(c), .above(above_w));

      always_comb begin
        v_d = in_valid;
        g_d = in_valid & above_w;
      end

      always_ff @(posedge clk or negedge rst_q) begin
        if (!rst_q) begin
          v_q <= 1'b0;
          g_q <= 1'b0;
        end else begin
          v_q <= v_d;
          g_q <= g_d;
        end
      end

      assign out_v     = v_q;
      assign out_g     = g_q;
      assign lane_done = '0;

    end else if (FORM == FORM_PIPE) begin : g_pipe
      logic [W:0]   sum_w, sum_q, sum_d;
      logic [W-1:0] thr_q, thr_d;
      logic         above_w, s1v_q, s1v_d, v_q, v_d, g_q, g_d;

      acd_sum #(.W(W)) u_sum (.op_a(a), .op_b(b), .sum(sum_w));
      acd_cmp #(.W(W)) u_cmp (.sum(sum_q), .thr(thr_q), .above(above_w));

      always_comb begin
        sum_d = in_valid ? sum_w : sum_q;
        thr_d = in_valid ? c : thr_q;
        s1v_d = in_valid;
        v_d   = s1v_q;
        g_d   = s1v_q & above_w;
      end

      always_ff @(posedge clk) begin
        sum_q <= sum_d;
        thr_q <= thr_d;
      end

      always_ff @(posedge clk or negedge rst_q) begin
        if (!rst_q) begin
          s1v_q <= 1'b0;
          v_q   <= 1'b0;
          g_q   <= 1'b0;
        end else begin
          s1v_q <= s1v_d;
          v_q   <= v_d;
          g_q   <= g_d;
        end
      end

      assign out_v     = v_q;
      assign out_g     = g_q;
      assign lane_done = '0;

    end else begin : g_par
      logic             turn_q, turn_d;
      logic [LANES-1:0] ld, lane_res;

      always_comb begin
        turn_d = in_valid ? ~turn_q : turn_q;
        ld[0]  = in_valid & ~turn_q;
        ld[1]  = in_valid &  turn_q;
      end

      always_ff @(posedge clk or negedge rst_q) begin
        if (!rst_q) turn_q <= 1'b0;
        else        turn_q <= turn_d;
      end

      for (genvar i = 0; i < LANES; i++) begin : g_lane
        acd_lane #(.W(W)) u_lane (
          .clk(clk), .rst_n(rst_q), .ld(ld[i]),
          .a(a), .b(b), .c(c),
          .done(lane_done[i]), .res(lane_res[i])
        );
      end

      // merge: lane 1 wins only when it reports
      assign out_v = |lane_done;
      assign out_g = lane_done[1] ? lane_res[1] : lane_res[0];
    end
  endgenerate

  assign out_valid = out_v;
  assign gt_out    = out_g;
endmodule

// File: rtl/acd_chk.sv
module acd_chk
  import acd_pkg::*;
#(
  parameter acd_form_e FORM = FORM_PAR,
  parameter int        W    = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] c,
  input logic         out_valid,
  input logic         gt_out,
  input logic [1:0]   lane_done
);
  localparam int LAT = form_latency(FORM);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= 2'd0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(since_rst) >= LAT) |-> (out_valid == $past(in_valid, LAT)));

  assert_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(since_rst) >= LAT) && out_valid) |->
      (gt_out == (({1'b0, $past(a, LAT)} + {1'b0, $past(b, LAT)}) > {1'b0, $past(c, LAT)})));

  assert_gt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !gt_out);

  assert_lane_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_done));

  always @(posedge clk) begin
    if (!rst_n) assert_reset_R7: assert (!out_valid && !gt_out);
  end
endmodule

bind add_cmp_dp acd_chk #(.FORM(FORM), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_q), .in_valid(in_valid),
  .a(a), .b(b), .c(c),
  .out_valid(out_valid), .gt_out(gt_out), .lane_done(lane_done)
);

// File: tb/add_cmp_dp_bench.sv
module add_cmp_dp_bench;
  import acd_pkg::*;

  localparam int W     = 8;
  localparam int DEPTH = 4096;
  localparam logic [W-1:0] MAXV = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] a = '0, b = '0, c = '0;
  logic [2:0]   ov, og;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  bit exp_v [3][DEPTH];
  bit exp_g [3][DEPTH];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // index 0: reference, 1: pipelined, 2: parallel
  add_cmp_dp #(.FORM(FORM_REF), .W(W)) u_add_cmp_dp_ref (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b), .c(c),
    .out_valid(ov[0]), .gt_out(og[0]));
  add_cmp_dp #(.FORM(FORM_PIPE), .W(W)) u_add_cmp_dp_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b), .c(c),
    .out_valid(ov[1]), .gt_out(og[1]));
  add_cmp_dp #(.FORM(FORM_PAR), .W(W)) u_add_cmp_dp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b), .c(c),
    .out_valid(ov[2]), .gt_out(og[2]));

  function automatic string form_tag(int k);
    case (k)
      0: return "R2";
      1: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic clear_from(input int first);
    for (int i = first; i < DEPTH; i++)
      for (int k = 0; k < 3; k++) begin
        exp_v[k][i] = 1'b0;
        exp_g[k][i] = 1'b0;
      end
  endtask

  // compare all three forms against the expectation for the current cycle
  task automatic check_now(input string note);
    for (int k = 0; k < 3; k++) begin
      checks++;
      if (ov[k] !== exp_v[k][cyc]) begin
        errors++;
        $display("FAIL %s/R5 %s form%0d cyc%0d out_valid actual=%b expected=%b",
                 form_tag(k), note, k, cyc, ov[k], exp_v[k][cyc]);
      end
      checks++;
      if (og[k] !== exp_g[k][cyc]) begin
        errors++;
        $display("FAIL %s %s form%0d cyc%0d gt_out actual=%b expected=%b",
                 exp_v[k][cyc] ? "R1" : "R8", note, k, cyc, og[k], exp_g[k][cyc]);
      end
    end
  endtask

  // called at a falling edge: check outputs, drive a sample, advance one cycle
  task automatic step(input logic v, input logic [W-1:0] ia, ib, ic,
                      input bit rec, input string note);
    int e;
    bit g;
    check_now(note);
    in_valid = v;
    a = ia;
    b = ib;
    c = ic;
    if (v && rec) begin
      e = cyc + 1;
      g = ({1'b0, ia} + {1'b0, ib}) > {1'b0, ic};
      for (int k = 0; k < 3; k++) begin
        exp_v[k][e + k] = 1'b1;
        exp_g[k][e + k] = g;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string note);
    for (int i = 0; i < n; i++) step(1'b0, W'($urandom), W'($urandom), W'($urandom), 1'b1, note);
  endtask

  task automatic t_reset_state;
    check_now("R7 reset state");
    idle(2, "R7 reset hold");
    rst_n = 1'b1;
    idle(4, "R7 release");
  endtask

  task automatic t_stream;
    for (int i = 0; i < 60; i++)
      step(1'b1, W'($urandom), W'($urandom), W'($urandom), 1'b1, "R5 back-to-back");
    idle(4, "R5 drain");
  endtask

  task automatic t_gaps;
    // irregular valid pattern with garbage operands in idle cycles (R6, R4 toggle)
    for (int i = 0; i < 80; i++)
      step(($urandom % 3) != 0, W'($urandom), W'($urandom), W'($urandom), 1'b1, "R6 gaps");
    step(1'b1, 8'd10, 8'd10, 8'd19, 1'b1, "R4 single");
    idle(1, "R4 gap");
    step(1'b1, 8'd10, 8'd10, 8'd20, 1'b1, "R4 single");
    idle(2, "R4 gap");
    step(1'b1, 8'd10, 8'd10, 8'd21, 1'b1, "R4 single");
    idle(5, "R6 drain");
  endtask

  task automatic t_bounds;
    step(1'b1, MAXV, MAXV, MAXV, 1'b1, "R1 carry");
    step(1'b1, 8'd128, 8'd128, MAXV, 1'b1, "R1 carry edge");
    step(1'b1, 8'd100, 8'd50, 8'd150, 1'b1, "R1 equal");
    step(1'b1, 8'd100, 8'd51, 8'd150, 1'b1, "R1 one above");
    step(1'b1, 8'd0, 8'd0, 8'd0, 1'b1, "R1 zeros");
    step(1'b1, 8'd0, 8'd0, MAXV, 1'b1, "R1 below");
    step(1'b1, MAXV, 8'd0, 8'd254, 1'b1, "R1 max minus one");
    step(1'b1, 8'd127, 8'd128, MAXV, 1'b1, "R1 equal at max");
    idle(5, "R1 drain");
  endtask

  task automatic t_midreset;
    for (int i = 0; i < 5; i++)
      step(1'b1, W'($urandom), W'($urandom), W'($urandom), 1'b1, "R7 before reset");
    rst_n = 1'b0;
    clear_from(cyc);
    #1;
    check_now("R7 in-flight discarded");
    @(negedge clk);
    for (int i = 0; i < 3; i++)
      step(1'b1, MAXV, MAXV, 8'd0, 1'b0, "R7 ignored during reset");
    rst_n = 1'b1;
    idle(3, "R7 release");
    for (int i = 0; i < 10; i++)
      step(1'b1, W'($urandom), W'($urandom), W'($urandom), 1'b1, "R7 after reset");
    idle(5, "R7 drain");
  endtask

  initial begin
    clear_from(0);
    @(negedge clk);
    t_reset_state();
    t_stream();
    t_gaps();
    t_bounds();
    t_midreset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule